// File: doc/BRIEF.md
# Masked Latching Over-Voltage Interrupt Controller

This block turns a synchronous over-voltage flag from an analog comparator into a sticky status bit. It qualifies that bit with a mask and drives the pull-down enable of an active-low, open-drain interrupt pin. Software sees two byte-wide registers through a simple register port. The status register can only be cleared by reading it, through a dedicated read strobe. The mask register is a plain read/write register. Event bits sit at the top of each register byte. With the default single source, that is bit 7.

The mask comes out of reset with the event masked. An event that arrives while masked is still recorded. The pin does not move until software clears the mask bit, and then it pulls the line low on the next cycle. Taking chip-enable low acts as a synchronous soft reset: status is cleared, the mask is restored, and the pin is released.

Top module: `ovp_irq_ctrl`

## Requirements
- R1: After `rst_n` is released, the status register reads 0x00, the mask register reads 0x80, and `int_pd_o` is 0 (pin released).
- R2: A rising edge of `evt_i` while `chip_en_i` is high sets status bit 7 at that clock edge. A flag that stays high does not set the bit again after it has been cleared.
- R3: Writes to the status address have no effect on status; only the read strobe clears it.
- R4: A cycle with `stat_rd_i` high returns the current status on `reg_rdata_o` and clears it at that edge. `int_pd_o` falls on the following edge.
- R5: If a new event edge arrives in the same cycle as a status read strobe, the status bit stays set.
- R6: `int_pd_o` is the registered value of (status AND NOT mask): it rises one cycle after an unmasked event is latched.
- R7: While mask bit 7 is 1, an event is still latched but `int_pd_o` stays 0. Writing 0 to the mask bit raises `int_pd_o` one cycle after the write edge.
- R8: Mask register bit 7 is read/write. Bits 6:0 of both registers ignore writes and read as zero.
- R9: While `chip_en_i` is low, status is held at 0x00, the mask at 0x80, and `int_pd_o` at 0. Register writes and events are ignored during that time.
- R10: Addresses other than the status and mask addresses read as 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en_i | input | 1 | Chip enable; low acts as a synchronous soft reset |
| evt_i | input | NUM_EVT | Synchronous over-voltage flags from the comparator |
| reg_addr_i | input | ADDR_W | Register address for read data and writes |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | DATA_W | Write data |
| stat_rd_i | input | 1 | Status read strobe; clears latched events |
| reg_rdata_o | output | DATA_W | Combinational read data for `reg_addr_i` |
| int_pd_o | output | 1 | Pull-down enable of the open-drain interrupt pin |

## Verification
The bench builds the block with one event source, an 8-bit data path, rising-edge capture, and the status and mask at addresses 0x2 and 0x3 of a 4-bit address space. That build places the event at bit 7 with the mask reset word 0x80. This brings within reach the remembered-while-masked case, a strobe that collides with a fresh edge, and a flag held high across a clear. A 4-bit address also leaves enough unmapped locations to check that they read as zero. The level-capture variant and wider source counts are covered only by the elaboration checks.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_STAT = 2'd1,
      SEL_MASK = 2'd2
   } irqc_sel_e;

   localparam int IRQC_LEVEL = 0;
   localparam int IRQC_EDGE  = 1;
endpackage

// File: rtl/irqc_evt_cond.sv
module irqc_evt_cond #(
   parameter int NUM_EVT   = 1,
   parameter int EDGE_MODE = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EVT-1:0] evt_i,
   output logic [NUM_EVT-1:0] hit_o,
   output logic [NUM_EVT-1:0] prev_o
);
   logic [NUM_EVT-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= evt_i;
   end

   generate
      if (EDGE_MODE == irqc_pkg::IRQC_EDGE) begin : g_edge
         assign hit_o = evt_i & ~prev_q;
      end else begin : g_level
         assign hit_o = evt_i;
      end
   endgenerate

   assign prev_o = prev_q;
endmodule

// File: rtl/irqc_stat.sv
module irqc_stat #(
   parameter int NUM_EVT = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               soft_clr_i,
   input  logic [NUM_EVT-1:0] hit_i,
   input  logic               rd_clr_i,
   output logic [NUM_EVT-1:0] stat_o
);
   genvar gi;
   generate
      for (gi = 0; gi < NUM_EVT; gi++) begin : g_bit
         logic bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          bit_q <= 1'b0;
            else if (soft_clr_i) bit_q <= 1'b0;
            else if (hit_i[gi])  bit_q <= 1'b1;
            else if (rd_clr_i)   bit_q <= 1'b0;
         end
         assign stat_o[gi] = bit_q;
      end
   endgenerate
endmodule

// File: rtl/irqc_mask.sv
module irqc_mask #(
   parameter int                 NUM_EVT  = 1,
   parameter logic [NUM_EVT-1:0] MASK_RST = '1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               soft_clr_i,
   input  logic               wr_i,
   input  logic [NUM_EVT-1:0] wdata_i,
   output logic [NUM_EVT-1:0] mask_o
);
   logic [NUM_EVT-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          mask_q <= MASK_RST;
      else if (soft_clr_i) mask_q <= MASK_RST;
      else if (wr_i)       mask_q <= wdata_i;
   end

   assign mask_o = mask_q;
endmodule

// File: rtl/irqc_pin.sv
module irqc_pin #(
   parameter int NUM_EVT = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               soft_clr_i,
   input  logic [NUM_EVT-1:0] stat_i,
   input  logic [NUM_EVT-1:0] mask_i,
   output logic               pd_o
);
   logic pend;
   logic pd_q;

   assign pend = |(stat_i & ~mask_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pd_q <= 1'b0;
      else if (soft_clr_i) pd_q <= 1'b0;
      else                 pd_q <= pend;
   end

   assign pd_o = pd_q;
endmodule

// File: rtl/ovp_irq_ctrl.sv
module ovp_irq_ctrl
   import irqc_pkg::*;
#(
   parameter int                NUM_EVT       = 1,
   parameter int                DATA_W        = 8,
   parameter int                ADDR_W        = 4,
   parameter int                EDGE_MODE     = IRQC_EDGE,
   parameter logic [ADDR_W-1:0] STAT_ADDR     = 4'h2,
   parameter logic [ADDR_W-1:0] MASK_ADDR     = 4'h3,
   parameter logic [DATA_W-1:0] MASK_RST_WORD = 8'h80
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               chip_en_i,
   input  logic [NUM_EVT-1:0] evt_i,
   input  logic [ADDR_W-1:0]  reg_addr_i,
   input  logic               reg_wr_i,
   input  logic [DATA_W-1:0]  reg_wdata_i,
   input  logic               stat_rd_i,
   output logic [DATA_W-1:0]  reg_rdata_o,
   output logic               int_pd_o
);
   localparam int                 SHIFT         = DATA_W - NUM_EVT;
   localparam logic [DATA_W-1:0]  RSVD_MASK     = DATA_W'((64'd1 << SHIFT) - 64'd1);
   localparam logic [NUM_EVT-1:0] MASK_RST_BITS = MASK_RST_WORD[DATA_W-1 -: NUM_EVT];

   generate
      if (NUM_EVT < 1 || NUM_EVT > DATA_W) begin : g_bad_num
         $error("NUM_EVT must lie between 1 and DATA_W");
      end
      if (STAT_ADDR == MASK_ADDR) begin : g_bad_addr
         $error("status and mask addresses must differ");
      end
      if (EDGE_MODE != IRQC_EDGE && EDGE_MODE != IRQC_LEVEL) begin : g_bad_mode
         $error("EDGE_MODE must be edge or level");
      end
      if ((MASK_RST_WORD & RSVD_MASK) != '0) begin : g_bad_rst
         $error("mask reset word sets reserved bits");
      end
   endgenerate

   logic               soft_clr;
   logic [NUM_EVT-1:0] hit;
   logic [NUM_EVT-1:0] evt_prev;
   logic [NUM_EVT-1:0] stat_q;
   logic [NUM_EVT-1:0] mask_q;
   irqc_sel_e          sel;
   logic               unused_wbits;

   assign soft_clr     = ~chip_en_i;
   assign unused_wbits = ^reg_wdata_i;

   always_comb begin
      if (reg_addr_i == STAT_ADDR)      sel = SEL_STAT;
      else if (reg_addr_i == MASK_ADDR) sel = SEL_MASK;
      else                              sel = SEL_NONE;
   end

   irqc_evt_cond #(.NUM_EVT(NUM_EVT), .EDGE_MODE(EDGE_MODE)) u_cond (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt_i  (evt_i),
      .hit_o  (hit),
      .prev_o (evt_prev)
   );

   irqc_stat #(.NUM_EVT(NUM_EVT)) u_stat (
      .clk        (clk),
      .rst_n      (rst_n),
      .soft_clr_i (soft_clr),
      .hit_i      (hit),
      .rd_clr_i   (stat_rd_i),
      .stat_o     (stat_q)
   );

   irqc_mask #(.NUM_EVT(NUM_EVT), .MASK_RST(MASK_RST_BITS)) u_mask (
      .clk        (clk),
      .rst_n      (rst_n),
      .soft_clr_i (soft_clr),
      .wr_i       (reg_wr_i && sel == SEL_MASK),
      .wdata_i    (reg_wdata_i[DATA_W-1 -: NUM_EVT]),
      .mask_o     (mask_q)
   );

   irqc_pin #(.NUM_EVT(NUM_EVT)) u_pin (
      .clk        (clk),
      .rst_n      (rst_n),
      .soft_clr_i (soft_clr),
      .stat_i     (stat_q),
      .mask_i     (mask_q),
      .pd_o       (int_pd_o)
   );

   always_comb begin
      unique case (sel)
         SEL_STAT: reg_rdata_o = DATA_W'(stat_q) << SHIFT;
         SEL_MASK: reg_rdata_o = DATA_W'(mask_q) << SHIFT;
         default:  reg_rdata_o = '0;
      endcase
   end
endmodule

// File: rtl/ovp_irq_ctrl_chk.sv
module ovp_irq_ctrl_chk #(
   parameter int                 NUM_EVT   = 1,
   parameter int                 EDGE_MODE = 1,
   parameter logic [NUM_EVT-1:0] MASK_RST  = '1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               chip_en,
   input logic [NUM_EVT-1:0] evt,
   input logic [NUM_EVT-1:0] evt_prev,
   input logic [NUM_EVT-1:0] stat_q,
   input logic [NUM_EVT-1:0] mask_q,
   input logic               stat_rd,
   input logic               int_pd
);
   logic [NUM_EVT-1:0] rise;
   assign rise = evt & ~evt_prev;

   a_r6_pd_follows_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (chip_en && |(stat_q & ~mask_q)) |=> int_pd);

   a_r7_pd_needs_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
      int_pd |-> $past(|(stat_q & ~mask_q)));

   a_r9_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
      !chip_en |=> (stat_q == '0 && mask_q == MASK_RST && !int_pd));

   generate
      if (EDGE_MODE == 1) begin : g_edge_props
         a_r2_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (chip_en && |rise) |=> ((stat_q & $past(rise)) == $past(rise)));

         a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (chip_en && stat_rd && rise == '0) |=> stat_q == '0);

         a_r3_set_only_by_event: assert property (@(posedge clk) disable iff (!rst_n)
            |(stat_q & ~$past(stat_q)) |-> $past(chip_en && |rise));
      end
   endgenerate
endmodule

bind ovp_irq_ctrl ovp_irq_ctrl_chk #(
   .NUM_EVT   (NUM_EVT),
   .EDGE_MODE (EDGE_MODE),
   .MASK_RST  (MASK_RST_BITS)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .chip_en  (chip_en_i),
   .evt      (evt_i),
   .evt_prev (evt_prev),
   .stat_q   (stat_q),
   .mask_q   (mask_q),
   .stat_rd  (stat_rd_i),
   .int_pd   (int_pd_o)
);

// File: tb/sim_ovp_irq_ctrl.sv
module sim_ovp_irq_ctrl;
   localparam int             DW     = 8;
   localparam int             AW     = 4;
   localparam logic [AW-1:0]  A_STAT = 4'h2;
   localparam logic [AW-1:0]  A_MASK = 4'h3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          chip_en = 1'b1;
   logic [0:0]    evt = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic          reg_wr = 1'b0;
   logic [DW-1:0] reg_wdata = '0;
   logic          stat_rd = 1'b0;
   logic [DW-1:0] reg_rdata;
   logic          int_pd;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   ovp_irq_ctrl #(
      .NUM_EVT(1), .DATA_W(DW), .ADDR_W(AW), .EDGE_MODE(1),
      .STAT_ADDR(A_STAT), .MASK_ADDR(A_MASK), .MASK_RST_WORD(8'h80)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .chip_en_i(chip_en), .evt_i(evt),
      .reg_addr_i(reg_addr), .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata),
      .stat_rd_i(stat_rd), .reg_rdata_o(reg_rdata), .int_pd_o(int_pd)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic peek(input logic [AW-1:0] a, input logic [7:0] exp, input string tag);
      reg_addr = a;
      #1;
      chk(tag, reg_rdata, exp);
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      step();
      reg_wr = 1'b0;
   endtask

   task automatic rd_clr(input logic [7:0] exp, input string tag);
      reg_addr = A_STAT; stat_rd = 1'b1;
      #1;
      chk(tag, reg_rdata, exp);
      step();
      stat_rd = 1'b0;
   endtask

   task automatic pulse();
      evt = 1'b1;
      step();
      evt = 1'b0;
   endtask

   task automatic t_reset();
      peek(A_STAT, 8'h00, "R1 status after reset");
      peek(A_MASK, 8'h80, "R1 mask after reset");
      chk("R1 pin released after reset", int_pd, 1'b0);
   endtask

   task automatic t_masked();
      pulse();
      chk("R7 pin quiet while masked", int_pd, 1'b0);
      step();
      chk("R7 pin still quiet", int_pd, 1'b0);
      peek(A_STAT, 8'h80, "R7 event remembered while masked");
      wr(A_MASK, 8'h00);
      chk("R7 pin not yet low at write edge", int_pd, 1'b0);
      step();
      chk("R7 pin low after unmask", int_pd, 1'b1);
      rd_clr(8'h80, "R4 read returns status");
      chk("R4 pin held one more cycle", int_pd, 1'b1);
      step();
      chk("R4 pin released after read", int_pd, 1'b0);
      peek(A_STAT, 8'h00, "R4 status cleared by read");
   endtask

   task automatic t_unmasked();
      pulse();
      chk("R6 pin lags status by one cycle", int_pd, 1'b0);
      step();
      chk("R6 pin asserted", int_pd, 1'b1);
      rd_clr(8'h80, "R6 status set");
      step();
      chk("R6 pin released", int_pd, 1'b0);
   endtask

   task automatic t_edge_only();
      evt = 1'b1;
      step();
      rd_clr(8'h80, "R2 edge latched");
      step(); step(); step();
      peek(A_STAT, 8'h00, "R2 held flag does not relatch");
      chk("R2 pin quiet with held flag", int_pd, 1'b0);
      evt = 1'b0;
      step();
      peek(A_STAT, 8'h00, "R2 falling edge ignored");
      evt = 1'b1;
      step();
      peek(A_STAT, 8'h80, "R2 new rising edge latched");
      evt = 1'b0;
      rd_clr(8'h80, "R2 clear");
      step(); step();
      chk("R2 pin released", int_pd, 1'b0);
   endtask

   task automatic t_same_cycle();
      pulse();
      step();
      evt = 1'b1; stat_rd = 1'b1; reg_addr = A_STAT;
      step();
      stat_rd = 1'b0; evt = 1'b0;
      peek(A_STAT, 8'h80, "R5 edge beats read clear");
      rd_clr(8'h80, "R5 clear");
      step();
      peek(A_STAT, 8'h00, "R5 cleared afterwards");
      step();
      chk("R5 pin released", int_pd, 1'b0);
   endtask

   task automatic t_status_ro();
      wr(A_STAT, 8'hFF);
      peek(A_STAT, 8'h00, "R3 write cannot set status");
      step();
      chk("R3 pin quiet after status write", int_pd, 1'b0);
      pulse();
      wr(A_STAT, 8'h00);
      peek(A_STAT, 8'h80, "R3 write cannot clear status");
      rd_clr(8'h80, "R3 clear");
      step(); step();
   endtask

   task automatic t_mask_bits();
      wr(A_MASK, 8'h7F);
      peek(A_MASK, 8'h00, "R8 reserved mask bits read zero");
      wr(A_MASK, 8'hFF);
      peek(A_MASK, 8'h80, "R8 mask bit writable");
      wr(A_MASK, 8'h00);
      peek(A_MASK, 8'h00, "R8 mask bit cleared");
   endtask

   task automatic t_unmapped();
      pulse();
      peek(4'h0, 8'h00, "R10 address 0 reads zero");
      peek(4'hF, 8'h00, "R10 address F reads zero");
      rd_clr(8'h80, "R10 clear");
      step(); step();
   endtask

   task automatic t_soft_reset();
      pulse();
      step();
      chk("R9 pin low before disable", int_pd, 1'b1);
      chip_en = 1'b0;
      step();
      peek(A_STAT, 8'h00, "R9 status cleared by disable");
      peek(A_MASK, 8'h80, "R9 mask restored by disable");
      chk("R9 pin released by disable", int_pd, 1'b0);
      wr(A_MASK, 8'h00);
      peek(A_MASK, 8'h80, "R9 write ignored while disabled");
      pulse();
      peek(A_STAT, 8'h00, "R9 event ignored while disabled");
      chip_en = 1'b1;
      step();
      peek(A_STAT, 8'h00, "R9 status after enable");
      peek(A_MASK, 8'h80, "R9 mask after enable");
      step();
      chk("R9 pin after enable", int_pd, 1'b0);
   endtask

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();
      t_reset();
      t_masked();
      t_unmasked();
      t_edge_only();
      t_same_cycle();
      t_status_ro();
      t_mask_bits();
      t_unmapped();
      t_soft_reset();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule